// File: doc/BRIEF.md
# Subset Variable-Length Instruction Field Decoder

This block takes a window of up to fifteen bytes that begins on an instruction boundary and splits one instruction of a small 64-bit-mode subset into its fields. The subset covers register moves, moves of an immediate into a register, and several add forms. The decoder recognises an optional operand-size prefix (0x66) and an optional register-extension prefix. It then finds the opcode, the optional operand-selector byte and any displacement, and collects a little-endian immediate of 1, 2, 4 or 8 bytes.

The results are the operation, the operand width, two 4-bit register numbers, an addressing-mode code, an immediate widened to 64 bits, the total byte length and an illegal flag. A fetch stage uses the length to advance to the next instruction. Decoding is a single registered stage. A window offered with `in_valid` high produces its result one clock later with `out_valid` high.

Top module: `ilen_field_dec`

## Requirements
- R1: After reset `out_valid` is 0. `out_valid` equals `in_valid` of the previous clock. While `in_valid` is low, every other output keeps its value.
- R2: Window byte k sits at `in_bytes[8k+7:8k]`. A 0x66 is recognised only at byte 0. A byte whose upper nibble is 0100 is taken as the register-extension prefix when it directly follows that point, with bit 3 = W, bit 2 = R, bit 1 = X and bit 0 = B. The next byte is the opcode. The `out_op` codes are 0 none, 1 move and 2 add.
- R3: The `out_width` codes are 0 for 8, 1 for 16, 2 for 32 and 3 for 64 bits. If the opcode's width bit is 0 the width is 8 bits, and any prefix is ignored. Otherwise W=1 gives 64 bits, 0x66 without W gives 16 bits, and anything else gives 32 bits.
- R4: The selector byte holds mode[7:6], reg[5:3] and base[2:0]. With a selector byte, the source is {R, reg} and the destination is {B, base}. For the 0xB0–0xBF forms, the destination is {B, opcode[2:0]}. X never changes any output.
- R5: The `out_mode` codes are 0 for register to register, 1 for immediate to register, 2 for memory at base, and 3 for memory at base plus an 8-bit displacement (one extra length byte). Immediate forms report a source of 0.
- R6: Opcodes 0xB0–0xBF are moves of an immediate, with opcode bit 3 as the width bit. The immediate is 1 byte when that bit is 0, 8 bytes with W, 2 bytes with 0x66, and otherwise 4 bytes. It is zero-extended to 64 bits.
- R7: The add forms are 0x00/0x01 (register, with selector byte), 0x04/0x05 (immediate into register 0), 0x80/0x81 (immediate of operand size) and 0x83 (8-bit immediate). For 0x80, 0x81 and 0x83 the reg field must be 0. An add immediate is 4 bytes at 32 or 64 bits, 2 bytes with 0x66, and 1 byte for 0x04, 0x80 and 0x83. It is sign-extended to 64 bits.
- R8: The length is the sum of the prefixes, the opcode, the selector byte, the displacement and the immediate. It is at most 15.
- R9: The instruction is illegal when the opcode is outside the subset, or selector mode is 10, or base is 100 in a memory mode, or mode 00 has base 101, or a 0x80/0x81/0x83 reg field is not 0, or the length exceeds 15. An illegal result gives `out_illegal`=1, length 1, and 0 on every other field.
- R10: `out_byte_legacy` is 1 when a legal instruction has 8-bit width and no register-extension prefix. In that case register codes 4–7 name the second bytes of the first four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window valid |
| in_bytes | input | 120 | Instruction byte window, byte 0 in the low bits |
| out_valid | output | 1 | Result valid |
| out_op | output | 2 | Operation code |
| out_width | output | 2 | Operand width code |
| out_src | output | 4 | Source register number |
| out_dst | output | 4 | Destination or base register number |
| out_mode | output | 2 | Addressing-mode code |
| out_imm | output | 64 | Extended immediate |
| out_len | output | 4 | Instruction length in bytes |
| out_illegal | output | 1 | Outside the subset |
| out_byte_legacy | output | 1 | 8-bit codes 4–7 name second bytes |

## Verification
The bench targets the places where prefix handling and field positions interact. These include a 64-bit immediate behind W and a 16-bit immediate behind both prefixes, where a wrong length or byte start would shift every later field. They also include a selector byte whose value is 0x66, which a design must not mistake for a prefix, and a 0x66 placed after the extension prefix, which must be illegal. Sign-extension cases use immediates with the top bit set. A design that zero-extended add immediates, or sign-extended move immediates, would return the wrong upper bits. Illegal selector modes, a non-zero reg field on the group opcodes and the legacy byte-register flag with and without an empty extension prefix are each checked. A design that dropped a rule would report a legal length or the wrong flag for these cases.

// File: rtl/ifd_pkg.sv
`timescale 1ns/1ps
package ifd_pkg;
   typedef enum logic [1:0] {OP_NONE = 2'd0, OP_MOV = 2'd1, OP_ADD = 2'd2} op_e;
   typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} size_e;
   typedef enum logic [1:0] {AM_RR = 2'd0, AM_IR = 2'd1, AM_MI = 2'd2, AM_MD = 2'd3} amode_e;
   typedef struct packed { logic w; logic r; logic x; logic b; } xpfx_t;
   typedef struct packed { logic [1:0] mm; logic [2:0] rrr; logic [2:0] bbb; } sel_t;
endpackage

// File: rtl/ifd_pfx_scan.sv
`timescale 1ns/1ps
module ifd_pfx_scan
   import ifd_pkg::*;
#(
   parameter int WIN_BYTES = 15
) (
   input  logic [WIN_BYTES*8-1:0] win,
   output logic                   osz,
   output logic                   xpresent,
   output xpfx_t                  xp,
   output logic [1:0]             idx,
   output logic [7:0]             opc,
   output logic [7:0]             sel
);
   logic [7:0] b0, b1, b2, b3, cand;
   assign b0 = win[7:0];
   assign b1 = win[15:8];
   assign b2 = win[23:16];
   assign b3 = win[31:24];

   always_comb begin
      osz      = (b0 == 8'h66);
      cand     = osz ? b1 : b0;
      xpresent = (cand[7:4] == 4'h4);
      xp       = xpresent ? xpfx_t'(cand[3:0]) : xpfx_t'(4'h0);
      idx      = {1'b0, osz} + {1'b0, xpresent};
      case (idx)
         2'd0:    begin opc = b0; sel = b1; end
         2'd1:    begin opc = b1; sel = b2; end
         default: begin opc = b2; sel = b3; end
      endcase
   end
endmodule

// File: rtl/ifd_opc_class.sv
`timescale 1ns/1ps
module ifd_opc_class
   import ifd_pkg::*;
(
   input  logic [7:0] opc,
   input  logic [7:0] sel_byte,
   input  logic       osz,
   input  xpfx_t      xp,
   output op_e        op,
   output size_e      size,
   output amode_e     amode,
   output logic [3:0] src,
   output logic [3:0] dst,
   output logic       has_sel,
   output logic       disp,
   output logic [3:0] imm_len,
   output logic       imm_sgn,
   output logic       bad
);
   sel_t sel;
   logic wbit, has_imm, grp;
   assign sel = sel_t'(sel_byte);

   always_comb begin
      op = OP_NONE; wbit = 1'b0; has_sel = 1'b0; has_imm = 1'b0;
      imm_len = 4'd0; imm_sgn = 1'b0; grp = 1'b0; bad = 1'b0;
      disp = 1'b0; amode = AM_RR; src = 4'd0; dst = 4'd0;
      case (opc)
         8'h88, 8'h89: begin op = OP_MOV; wbit = opc[0]; has_sel = 1'b1; end
         8'h00, 8'h01: begin op = OP_ADD; wbit = opc[0]; has_sel = 1'b1; end
         8'h04, 8'h05: begin
            op = OP_ADD; wbit = opc[0]; has_imm = 1'b1; imm_sgn = 1'b1;
            imm_len = !wbit ? 4'd1 : (osz && !xp.w) ? 4'd2 : 4'd4;
         end
         8'h80, 8'h81, 8'h83: begin
            op = OP_ADD; wbit = (opc != 8'h80); has_sel = 1'b1; has_imm = 1'b1;
            imm_sgn = 1'b1; grp = 1'b1;
            imm_len = (opc != 8'h81) ? 4'd1 : (osz && !xp.w) ? 4'd2 : 4'd4;
         end
         default: begin
            if (opc[7:4] == 4'hB) begin
               op = OP_MOV; wbit = opc[3]; has_imm = 1'b1;
               imm_len = !wbit ? 4'd1 : xp.w ? 4'd8 : osz ? 4'd2 : 4'd4;
            end else begin
               bad = 1'b1;
            end
         end
      endcase

      if (has_sel) begin
         dst = {xp.b, sel.bbb};
         src = has_imm ? 4'd0 : {xp.r, sel.rrr};
         case (sel.mm)
            2'b11: amode = has_imm ? AM_IR : AM_RR;
            2'b00: amode = AM_MI;
            2'b01: begin amode = AM_MD; disp = 1'b1; end
            default: bad = 1'b1;
         endcase
         if (sel.mm != 2'b11 && sel.bbb == 3'b100) bad = 1'b1;
         if (sel.mm == 2'b00 && sel.bbb == 3'b101) bad = 1'b1;
         if (grp && sel.rrr != 3'b000) bad = 1'b1;
      end else if (has_imm) begin
         amode = AM_IR;
         dst   = (opc[7:4] == 4'hB) ? {xp.b, opc[2:0]} : 4'd0;
      end

      if (!wbit)      size = SZ_8;
      else if (xp.w)  size = SZ_64;
      else if (osz)   size = SZ_16;
      else            size = SZ_32;
   end
endmodule

// File: rtl/ifd_imm_gather.sv
`timescale 1ns/1ps
module ifd_imm_gather #(
   parameter int WIN_BYTES = 15,
   parameter int IMM_BYTES = 8
) (
   input  logic [WIN_BYTES*8-1:0] win,
   input  logic [3:0]             start,
   input  logic [3:0]             len,
   input  logic                   sgn,
   output logic [IMM_BYTES*8-1:0] imm
);
   localparam int WIN_W = WIN_BYTES * 8;
   logic [WIN_W-1:0] shifted;
   logic             msb;
   logic [7:0]       fill;

   assign shifted = win >> {start, 3'b000};

   always_comb begin
      msb = 1'b0;
      for (int k = 0; k < IMM_BYTES; k++)
         if (4'(k + 1) == len) msb = shifted[k*8+7];
   end
   assign fill = (sgn && msb) ? 8'hFF : 8'h00;

   for (genvar k = 0; k < IMM_BYTES; k++) begin : g_byte
      if (k < WIN_BYTES) begin : g_in
         assign imm[k*8 +: 8] = (4'(k) < len) ? shifted[k*8 +: 8] : fill;
      end else begin : g_out
         assign imm[k*8 +: 8] = fill;
      end
   end
endmodule

// File: rtl/ilen_field_dec.sv
`timescale 1ns/1ps
module ilen_field_dec
   import ifd_pkg::*;
#(
   parameter int WIN_BYTES = 15,
   parameter int MAX_LEN   = 15,
   parameter int IMM_BYTES = 8,
   localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [WIN_BYTES*8-1:0] in_bytes,
   output logic                   out_valid,
   output logic [1:0]             out_op,
   output logic [1:0]             out_width,
   output logic [3:0]             out_src,
   output logic [3:0]             out_dst,
   output logic [1:0]             out_mode,
   output logic [IMM_BYTES*8-1:0] out_imm,
   output logic [LEN_W-1:0]       out_len,
   output logic                   out_illegal,
   output logic                   out_byte_legacy
);
   if (WIN_BYTES < MAX_LEN) begin : g_chk_win
      $error("window narrower than the longest instruction");
   end
   if (IMM_BYTES != 8) begin : g_chk_imm
      $error("immediate output must be 8 bytes");
   end
   if (LEN_W != 4) begin : g_chk_len
      $error("length field must be 4 bits");
   end

   logic        osz, xpresent, has_sel, disp, imm_sgn, bad, ill;
   xpfx_t       xp;
   logic [1:0]  idx;
   logic [7:0]  opc, sel_byte;
   op_e         op;
   size_e       size;
   amode_e      amode;
   logic [3:0]  src, dst, imm_len, imm_start;
   logic [4:0]  len_sum;
   logic [IMM_BYTES*8-1:0] imm;

   ifd_pfx_scan #(.WIN_BYTES(WIN_BYTES)) u_pfx (
      .win(in_bytes), .osz(osz), .xpresent(xpresent), .xp(xp),
      .idx(idx), .opc(opc), .sel(sel_byte)
   );

   ifd_opc_class u_cls (
      .opc(opc), .sel_byte(sel_byte), .osz(osz), .xp(xp), .op(op), .size(size),
      .amode(amode), .src(src), .dst(dst), .has_sel(has_sel), .disp(disp),
      .imm_len(imm_len), .imm_sgn(imm_sgn), .bad(bad)
   );

   assign imm_start = {2'b00, idx} + 4'd1 + {3'b000, has_sel} + {3'b000, disp};
   assign len_sum   = {1'b0, imm_start} + {1'b0, imm_len};
   assign ill       = bad || (len_sum > 5'(MAX_LEN));

   ifd_imm_gather #(.WIN_BYTES(WIN_BYTES), .IMM_BYTES(IMM_BYTES)) u_imm (
      .win(in_bytes), .start(imm_start), .len(imm_len), .sgn(imm_sgn), .imm(imm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0; out_op <= 2'd0; out_width <= 2'd0; out_src <= 4'd0;
         out_dst <= 4'd0; out_mode <= 2'd0; out_imm <= '0; out_len <= '0;
         out_illegal <= 1'b0; out_byte_legacy <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_illegal <= ill;
            if (ill) begin
               out_op <= OP_NONE; out_width <= 2'd0; out_src <= 4'd0; out_dst <= 4'd0;
               out_mode <= 2'd0; out_imm <= '0; out_len <= LEN_W'(1);
               out_byte_legacy <= 1'b0;
            end else begin
               out_op <= op; out_width <= size; out_src <= src; out_dst <= dst;
               out_mode <= amode; out_imm <= imm; out_len <= LEN_W'(len_sum);
               out_byte_legacy <= (size == SZ_8) && !xpresent;
            end
         end
      end
   end
endmodule

// File: rtl/ilen_field_chk.sv
`timescale 1ns/1ps
module ilen_field_chk #(
   parameter int WIN_BYTES = 15,
   parameter int LEN_W     = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [WIN_BYTES*8-1:0] in_bytes,
   input logic                   out_valid,
   input logic [1:0]             out_op,
   input logic [1:0]             out_width,
   input logic [3:0]             out_src,
   input logic [3:0]             out_dst,
   input logic [1:0]             out_mode,
   input logic [63:0]            out_imm,
   input logic [LEN_W-1:0]       out_len,
   input logic                   out_illegal,
   input logic                   out_byte_legacy
);
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_len) && $stable(out_imm) && $stable(out_op));
   p_legal_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_illegal |-> out_op != 2'd0 && out_op != 2'd3);
   p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_len >= LEN_W'(1) && out_len <= LEN_W'(15));
   p_illegal_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_illegal |-> out_len == LEN_W'(1) && out_op == 2'd0 && out_imm == 64'd0);
   p_legacy_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_byte_legacy |-> out_width == 2'd0 && !out_illegal);
   p_mov_imm_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_op == 2'd1 && out_mode == 2'd1 && out_width == 2'd0
      |-> out_imm[63:8] == 56'd0);
   p_imm_src_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_mode == 2'd1 |-> out_src == 4'd0);
endmodule

bind ilen_field_dec ilen_field_chk #(.WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_ilen_field_dec.sv
`timescale 1ns/1ps
module tb_ilen_field_dec;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [119:0] in_bytes = '0;
   logic         out_valid, out_illegal, out_byte_legacy;
   logic [1:0]   out_op, out_width, out_mode;
   logic [3:0]   out_src, out_dst, out_len;
   logic [63:0]  out_imm;
   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   ilen_field_dec dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
      .out_valid(out_valid), .out_op(out_op), .out_width(out_width), .out_src(out_src),
      .out_dst(out_dst), .out_mode(out_mode), .out_imm(out_imm), .out_len(out_len),
      .out_illegal(out_illegal), .out_byte_legacy(out_byte_legacy)
   );

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
      end
   end

   task automatic ck(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [119:0] pk(input logic [7:0] a0, a1 = 0, a2 = 0, a3 = 0,
                                       a4 = 0, a5 = 0, a6 = 0, a7 = 0, a8 = 0, a9 = 0);
      return {40'd0, a9, a8, a7, a6, a5, a4, a3, a2, a1, a0};
   endfunction

   task automatic apply(input logic [119:0] w);
      @(negedge clk);
      in_bytes = w; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_ok(input string tag, input logic [119:0] w, input logic [1:0] op,
                            input logic [1:0] wd, input logic [3:0] s, input logic [3:0] d,
                            input logic [1:0] md, input logic [63:0] imm,
                            input logic [3:0] ln, input logic l8);
      apply(w);
      ck({tag, " valid"}, 64'(out_valid), 64'd1);
      ck({tag, " illegal"}, 64'(out_illegal), 64'd0);
      ck({tag, " op"}, 64'(out_op), 64'(op));
      ck({tag, " width"}, 64'(out_width), 64'(wd));
      ck({tag, " src"}, 64'(out_src), 64'(s));
      ck({tag, " dst"}, 64'(out_dst), 64'(d));
      ck({tag, " mode"}, 64'(out_mode), 64'(md));
      ck({tag, " imm"}, out_imm, imm);
      ck({tag, " len"}, 64'(out_len), 64'(ln));
      ck({tag, " legacy"}, 64'(out_byte_legacy), 64'(l8));
   endtask

   task automatic expect_bad(input string tag, input logic [119:0] w);
      apply(w);
      ck({tag, " illegal"}, 64'(out_illegal), 64'd1);
      ck({tag, " len"}, 64'(out_len), 64'd1);
      ck({tag, " op"}, 64'(out_op), 64'd0);
      ck({tag, " imm"}, out_imm, 64'd0);
   endtask

   task automatic t_reset();
      ck("R1 reset valid", 64'(out_valid), 64'd0);
      ck("R1 reset len", 64'(out_len), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      ck("R1 idle valid", 64'(out_valid), 64'd0);
   endtask

   task automatic t_mov_imm();
      expect_ok("R6 mov imm64", pk(8'h49, 8'hBA, 8'hEF, 8'hCD, 8'hAB, 8'h90, 8'h78, 8'h56, 8'h34, 8'h12),
                2'd1, 2'd3, 4'd0, 4'd10, 2'd1, 64'h1234567890ABCDEF, 4'd10, 1'b0);
      expect_ok("R6 mov imm32", pk(8'h41, 8'hBB, 8'h78, 8'h56, 8'h34, 8'hF2),
                2'd1, 2'd2, 4'd0, 4'd11, 2'd1, 64'h00000000F2345678, 4'd6, 1'b0);
      expect_ok("R3 mov imm16 both prefixes", pk(8'h66, 8'h41, 8'hBC, 8'h34, 8'h12),
                2'd1, 2'd1, 4'd0, 4'd12, 2'd1, 64'h1234, 4'd5, 1'b0);
      expect_ok("R10 mov imm8 extended", pk(8'h41, 8'hB5, 8'h92),
                2'd1, 2'd0, 4'd0, 4'd13, 2'd1, 64'h92, 4'd3, 1'b0);
   endtask

   task automatic t_reg_forms();
      expect_ok("R4 mov rr 64", pk(8'h49, 8'h89, 8'hC2), 2'd1, 2'd3, 4'd0, 4'd10, 2'd0, 64'd0, 4'd3, 1'b0);
      expect_ok("R4 X ignored", pk(8'h4A, 8'h89, 8'hC2), 2'd1, 2'd3, 4'd0, 4'd2, 2'd0, 64'd0, 4'd3, 1'b0);
      expect_ok("R4 mov rr 8", pk(8'h41, 8'h88, 8'hDD), 2'd1, 2'd0, 4'd3, 4'd13, 2'd0, 64'd0, 4'd3, 1'b0);
      expect_ok("R4 add rr R bit", pk(8'h4C, 8'h01, 8'hD0), 2'd2, 2'd3, 4'd10, 4'd0, 2'd0, 64'd0, 4'd3, 1'b0);
      expect_ok("R3 0x66 ignored at 8 bit", pk(8'h66, 8'h88, 8'hC3), 2'd1, 2'd0, 4'd0, 4'd3, 2'd0, 64'd0, 4'd3, 1'b1);
   endtask

   task automatic t_mem_forms();
      expect_ok("R5 mem indirect", pk(8'h88, 8'h07), 2'd1, 2'd0, 4'd0, 4'd7, 2'd2, 64'd0, 4'd2, 1'b1);
      expect_ok("R5 mem disp8 sel=0x66", pk(8'h4C, 8'h89, 8'h66, 8'h18), 2'd1, 2'd3, 4'd12, 4'd6, 2'd3, 64'd0, 4'd4, 1'b0);
      expect_ok("R7 add mem disp8 imm", pk(8'h80, 8'h47, 8'h10, 8'h05), 2'd2, 2'd0, 4'd0, 4'd7, 2'd3, 64'd5, 4'd4, 1'b1);
   endtask

   task automatic t_add_imm();
      expect_ok("R7 add rax imm32 sext", pk(8'h48, 8'h05, 8'h00, 8'h00, 8'h00, 8'h80),
                2'd2, 2'd3, 4'd0, 4'd0, 2'd1, 64'hFFFFFFFF80000000, 4'd6, 1'b0);
      expect_ok("R7 add al imm8", pk(8'h04, 8'hFF), 2'd2, 2'd0, 4'd0, 4'd0, 2'd1, 64'hFFFFFFFFFFFFFFFF, 4'd2, 1'b1);
      expect_ok("R7 add 0x83 sext", pk(8'h83, 8'hC1, 8'hF0), 2'd2, 2'd2, 4'd0, 4'd1, 2'd1, 64'hFFFFFFFFFFFFFFF0, 4'd3, 1'b0);
      expect_ok("R7 add 0x81 imm16", pk(8'h66, 8'h81, 8'hC2, 8'h34, 8'h12), 2'd2, 2'd1, 4'd0, 4'd2, 2'd1, 64'h1234, 4'd5, 1'b0);
      expect_ok("R8 add 0x81 W over 0x66", pk(8'h66, 8'h49, 8'h81, 8'hC0, 8'h01, 8'h00, 8'h00, 8'h00),
                2'd2, 2'd3, 4'd0, 4'd8, 2'd1, 64'd1, 4'd8, 1'b0);
   endtask

   task automatic t_legacy();
      expect_ok("R10 no prefix", pk(8'h88, 8'hE6), 2'd1, 2'd0, 4'd4, 4'd6, 2'd0, 64'd0, 4'd2, 1'b1);
      expect_ok("R10 empty extension prefix", pk(8'h40, 8'h88, 8'hE6), 2'd1, 2'd0, 4'd4, 4'd6, 2'd0, 64'd0, 4'd3, 1'b0);
   endtask

   task automatic t_illegal();
      expect_bad("R9 push", pk(8'h55));
      expect_bad("R9 ret", pk(8'hC3));
      expect_bad("R9 mode 10", pk(8'h89, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00));
      expect_bad("R9 index byte", pk(8'h89, 8'h04, 8'h24));
      expect_bad("R9 mode00 base101", pk(8'h89, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00));
      expect_bad("R9 group reg nonzero", pk(8'h81, 8'hC8, 8'h01, 8'h00, 8'h00, 8'h00));
      expect_bad("R2 0x66 after extension", pk(8'h48, 8'h66, 8'h89, 8'hC0));
      expect_bad("R2 double 0x66", pk(8'h66, 8'h66, 8'h89, 8'hC0));
   endtask

   task automatic t_hold();
      apply(pk(8'h41, 8'hBB, 8'h78, 8'h56, 8'h34, 8'h12));
      @(negedge clk);
      ck("R1 drop valid", 64'(out_valid), 64'd0);
      ck("R1 hold imm", out_imm, 64'h12345678);
      ck("R1 hold len", 64'(out_len), 64'd6);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_mov_imm();
      t_reg_forms();
      t_mem_forms();
      t_add_imm();
      t_legacy();
      t_illegal();
      t_hold();
      summary();
   end
endmodule